// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Sequencer

This block is the host side of a four-wire serial link to a sigma-delta analog-to-digital converter. A single start pulse starts one complete conversion transaction under one chip-select window. The block pulls chip select low and, if the caller asks for it, writes a new 24-bit value into the converter's configuration register. It then waits a programmable number of system clocks while the converter settles and converts. After that it sends the data-register read command, shifts in the 24-bit result and releases chip select.

The serial clock idles high. Outgoing bits change on its falling edge and incoming bits are sampled on its rising edge. Each half period of the serial clock lasts `HALF_DIV` system clocks. The settling wait is taken from an input, so a system can program a delay of the order of 100 ms and a simulation can use a short one. The caller sees a busy flag for the length of the transaction and a one-cycle valid strobe that comes with the result.

Top module: `sdadc_spi_seq`

## Requirements
- R1: Every word is sent and received most significant bit first. Chip select stays low from the first serial clock edge of a transaction to the last, and the serial clock never toggles while chip select is high.
- R2: The serial clock idles high. MOSI changes only on a falling edge and MISO is sampled on a rising edge. Each low or high phase of the serial clock lasts exactly `HALF_DIV` system clocks.
- R3: When `cfg_wr_i` is 1 at start, the first 32 bits on MOSI are the command byte 0x10 followed by `cfg_word_i[23:0]`. The command byte is, from bit 7 down: write-enable 0, read/not-write 0, register address 3'd2, continuous-read 0, then 2'b00.
- R4: When `cfg_wr_i` is 0 at start, the configuration write is skipped and exactly 32 serial clock cycles occur in the transaction.
- R5: The read phase sends the command byte 0x58 (write-enable 0, read 1, address 3'd3, continuous-read 0, 2'b00), and MOSI is low for the 24 clock cycles that follow it.
- R6: At least `settle_cycles_i` system clocks pass, with the serial clock held high, between the reference point and the first falling edge of the read phase. The reference point is the fall of chip select, or the last rising edge of the configuration write when there is one. The delay is at most `settle_cycles_i` + 2·`HALF_DIV` + 8 clocks.
- R7: `result_o` holds the 24 MISO bits sampled after the read command byte, first bit in bit 23. Chip select rises in the same cycle that `result_vld_o` is high.
- R8: `result_vld_o` is high for exactly one system clock per transaction.
- R9: `busy_o` is high from the cycle after an accepted start until the cycle in which chip select rises. A start pulse while `busy_o` is high changes neither the bits sent nor the number of results.
- R10: After reset, `spi_cs_n_o`=1, `spi_sclk_o`=1, `spi_mosi_o`=0, `busy_o`=0 and `result_vld_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a transaction |
| cfg_wr_i | input | 1 | Write the configuration register in this transaction |
| cfg_word_i | input | WORD_W | Configuration register value |
| settle_cycles_i | input | DLY_W | Settling wait in system clocks |
| result_o | output | WORD_W | Last conversion result |
| result_vld_o | output | 1 | One-cycle strobe when `result_o` is updated |
| busy_o | output | 1 | Transaction in progress |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_sclk_o | output | 1 | Serial clock, idles high |
| spi_mosi_o | output | 1 | Serial data to the converter |
| spi_miso_i | input | 1 | Serial data from the converter |

## Verification
The bench models the converter. It records every MOSI bit at rising edges and presents result bits on falling edges. It sends result patterns of all zeros, all ones, a lone MSB and random values, so a design that drops a bit or samples on the wrong edge returns a shifted or wrong word. Settling delays of 0 and of a long value, with and without a configuration write, expose a delay counter that is skipped, off by a phase or started from the wrong point. Start pulses injected mid-transaction catch a sequencer that restarts or sends a second frame, which would show up as extra MOSI bits or a second valid strobe.

// File: rtl/sdadc_pkg.sv
// Package: shared constants, command encoding and sequencer state type
// for the sigma-delta serial sequencer.
// Assumes the converter's command byte layout: [7] write-enable (active low),
// [6] read/not-write, [5:3] register address, [2] continuous read, [1:0] zero.
package sdadc_pkg;

    localparam int CMD_W = 8;

    localparam logic [2:0] REG_ADDR_CFG  = 3'd2;
    localparam logic [2:0] REG_ADDR_DATA = 3'd3;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_CFG    = 2'd1,
        SEQ_SETTLE = 2'd2,
        SEQ_READ   = 2'd3
    } seq_state_t;

    // Builds a command byte for a single (non-continuous) register access.
    function automatic logic [CMD_W-1:0] make_cmd(input logic rd, input logic [2:0] addr);
        make_cmd = {1'b0, rd, addr, 1'b0, 2'b00};
    endfunction

endpackage

// File: rtl/sdadc_bit_engine.sv
// Module: serial bit engine, clock idle high, shift on fall, sample on rise.
// Moves one fixed-length frame of XFER_W bits per go pulse, MSB first.
// Keeps the last RX_W received bits. Assumes go_i is only pulsed while
// the engine is idle, and HALF_DIV >= 1.
module sdadc_bit_engine #(
    parameter int HALF_DIV = 2,
    parameter int XFER_W   = 32,
    parameter int RX_W     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [XFER_W-1:0] tx_word_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              done_o,
    output logic [RX_W-1:0]   rx_word_o
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(XFER_W + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic              active;
    logic [DIV_W-1:0]  div_cnt;
    logic [BIT_W-1:0]  bits_left;
    logic [XFER_W-1:0] tx_sh;
    logic [RX_W-1:0]   rx_sh;

    // Frame engine: divides the clock, shifts MOSI on falls, captures MISO on rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            div_cnt   <= '0;
            bits_left <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sclk_o    <= 1'b1;
            mosi_o    <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!active) begin
                if (go_i) begin
                    active    <= 1'b1;
                    tx_sh     <= tx_word_i;
                    bits_left <= BIT_W'(XFER_W);
                    div_cnt   <= '0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (sclk_o) begin
                    sclk_o <= 1'b0;
                    mosi_o <= tx_sh[XFER_W-1];
                    tx_sh  <= {tx_sh[XFER_W-2:0], 1'b0};
                end else begin
                    sclk_o    <= 1'b1;
                    rx_sh     <= {rx_sh[RX_W-2:0], miso_i};
                    bits_left <= bits_left - 1'b1;
                    if (bits_left == BIT_W'(1)) begin
                        active <= 1'b0;
                        done_o <= 1'b1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign rx_word_o = rx_sh;

    AST_SCLK_LOW_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_o |-> active) else $error("sclk low outside a frame"); // R2
    AST_BITS_NOT_EXHAUSTED: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bits_left != '0)) else $error("bit counter underflow"); // R1
    AST_DONE_WITH_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sclk_o && !active)) else $error("frame ended with clock low"); // R2

endmodule

// File: rtl/sdadc_settle_timer.sv
// Module: settling delay timer. A load pulse captures a count N. After at
// least N further clocks, a single-cycle expired pulse is emitted.
// Assumes load_i is not pulsed again while a countdown is running.
module sdadc_settle_timer #(
    parameter int DLY_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] count_i,
    output logic             expired_o
);

    logic [DLY_W-1:0] remain;
    logic             armed;

    // Countdown: load, decrement to zero, then pulse expired once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain    <= '0;
            armed     <= 1'b0;
            expired_o <= 1'b0;
        end else begin
            expired_o <= 1'b0;
            if (load_i) begin
                remain <= count_i;
                armed  <= 1'b1;
            end else if (armed) begin
                if (remain == '0) begin
                    armed     <= 1'b0;
                    expired_o <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> !expired_o) else $error("expired held"); // R6
    AST_NOT_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !expired_o) else $error("expired right after load"); // R6

endmodule

// File: rtl/sdadc_spi_seq.sv
// Module: top-level transaction sequencer for a sigma-delta converter.
// A start pulse opens one chip-select window. Inside it the block runs an
// optional configuration write, a settling wait and a data-register read,
// then releases chip select and presents the result with a one-cycle strobe.
// Assumes the converter returns its result right after the read command byte.
module sdadc_spi_seq
    import sdadc_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int WORD_W   = 24,
    parameter int DLY_W    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cfg_wr_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    input  logic [DLY_W-1:0]  settle_cycles_i,
    output logic [WORD_W-1:0] result_o,
    output logic              result_vld_o,
    output logic              busy_o,
    output logic              spi_cs_n_o,
    output logic              spi_sclk_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i
);

    localparam int XFER_W = CMD_W + WORD_W;
    localparam logic [CMD_W-1:0] CMD_CFG_WRITE = make_cmd(1'b0, REG_ADDR_CFG);
    localparam logic [CMD_W-1:0] CMD_DATA_READ = make_cmd(1'b1, REG_ADDR_DATA);

    seq_state_t        state;
    logic              eng_go;
    logic              eng_done;
    logic [XFER_W-1:0] eng_tx;
    logic [WORD_W-1:0] eng_rx;
    logic              tmr_load;
    logic              tmr_expired;
    logic [DLY_W-1:0]  settle_q;

    // Frame engine shared by the configuration write and the data read.
    sdadc_bit_engine #(
        .HALF_DIV (HALF_DIV),
        .XFER_W   (XFER_W),
        .RX_W     (WORD_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (eng_go),
        .tx_word_i (eng_tx),
        .miso_i    (spi_miso_i),
        .sclk_o    (spi_sclk_o),
        .mosi_o    (spi_mosi_o),
        .done_o    (eng_done),
        .rx_word_o (eng_rx)
    );

    // Settling wait between chip-select assertion or configuration and the read.
    sdadc_settle_timer #(
        .DLY_W (DLY_W)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .count_i   (settle_q),
        .expired_o (tmr_expired)
    );

    // Transaction sequencer: chip select, phase order, result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SEQ_IDLE;
            spi_cs_n_o   <= 1'b1;
            eng_go       <= 1'b0;
            eng_tx       <= '0;
            tmr_load     <= 1'b0;
            settle_q     <= '0;
            result_o     <= '0;
            result_vld_o <= 1'b0;
        end else begin
            eng_go       <= 1'b0;
            tmr_load     <= 1'b0;
            result_vld_o <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (start_i) begin
                        spi_cs_n_o <= 1'b0;
                        settle_q   <= settle_cycles_i;
                        if (cfg_wr_i) begin
                            eng_tx <= {CMD_CFG_WRITE, cfg_word_i};
                            eng_go <= 1'b1;
                            state  <= SEQ_CFG;
                        end else begin
                            tmr_load <= 1'b1;
                            state    <= SEQ_SETTLE;
                        end
                    end
                end
                SEQ_CFG: begin
                    if (eng_done) begin
                        tmr_load <= 1'b1;
                        state    <= SEQ_SETTLE;
                    end
                end
                SEQ_SETTLE: begin
                    if (tmr_expired) begin
                        eng_tx <= {CMD_DATA_READ, {WORD_W{1'b0}}};
                        eng_go <= 1'b1;
                        state  <= SEQ_READ;
                    end
                end
                SEQ_READ: begin
                    if (eng_done) begin
                        result_o     <= eng_rx;
                        result_vld_o <= 1'b1;
                        spi_cs_n_o   <= 1'b1;
                        state        <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Busy covers every cycle between an accepted start and chip-select release.
    always_comb busy_o = (state != SEQ_IDLE);

    AST_NO_SCLK_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sclk_o |-> !spi_cs_n_o) else $error("clock toggles with cs high"); // R1
    AST_SETTLE_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SETTLE) |-> spi_sclk_o) else $error("clock moved during settle"); // R6
    AST_RELEASE_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n_o) |-> result_vld_o) else $error("cs released without result"); // R7
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld_o |=> !result_vld_o) else $error("valid longer than one cycle"); // R8
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> spi_cs_n_o) else $error("cs low while idle"); // R9

endmodule

// File: tb/sdadc_spi_seq_test.sv
// Bench: converter model on the serial pins, directed corners plus seeded
// random transactions, expected frames computed from the requirements.
module sdadc_spi_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int WORD_W     = 24;
    localparam int DLY_W      = 24;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              cfg_wr_i = 1'b0;
    logic [WORD_W-1:0] cfg_word_i = '0;
    logic [DLY_W-1:0]  settle_cycles_i = '0;
    logic [WORD_W-1:0] result_o;
    logic              result_vld_o;
    logic              busy_o;
    logic              spi_cs_n_o;
    logic              spi_sclk_o;
    logic              spi_mosi_o;
    logic              spi_miso_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    // Converter model state (written only by the monitor process).
    logic [63:0] mosi_log = '0;
    int  mosi_bits  = 0;
    int  falls      = 0;
    int  idle_edges = 0;
    int  half_err   = 0;
    int  vld_cnt    = 0;
    longint cyc       = 0;
    longint t_cs      = 0;
    longint t_fall    = 0;
    longint t_cfg_end = 0;
    longint t_rd_fall = 0;
    logic prev_cs   = 1'b1;
    logic prev_sclk = 1'b1;

    // Stimulus-side model settings (written only by the driver).
    int          rd_base  = 0;
    logic [23:0] dev_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdadc_spi_seq #(
        .HALF_DIV (HALF_DIV),
        .WORD_W   (WORD_W),
        .DLY_W    (DLY_W)
    ) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .cfg_wr_i        (cfg_wr_i),
        .cfg_word_i      (cfg_word_i),
        .settle_cycles_i (settle_cycles_i),
        .result_o        (result_o),
        .result_vld_o    (result_vld_o),
        .busy_o          (busy_o),
        .spi_cs_n_o      (spi_cs_n_o),
        .spi_sclk_o      (spi_sclk_o),
        .spi_mosi_o      (spi_mosi_o),
        .spi_miso_i      (spi_miso_i)
    );

    // Converter model: watches pins between clock edges, answers on falls.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && result_vld_o) vld_cnt = vld_cnt + 1;
        if (prev_cs && !spi_cs_n_o) begin
            mosi_bits = 0; falls = 0; mosi_log = '0; t_cs = cyc;
        end
        if (prev_sclk && !spi_sclk_o) begin
            if (spi_cs_n_o) idle_edges = idle_edges + 1;
            t_fall = cyc;
            if (falls == rd_base) t_rd_fall = cyc;
            if (falls - rd_base >= 8 && falls - rd_base < 32)
                spi_miso_i <= dev_word[31 - (falls - rd_base)];
            else
                spi_miso_i <= 1'b1;
            falls = falls + 1;
        end
        if (!prev_sclk && spi_sclk_o) begin
            if (spi_cs_n_o) idle_edges = idle_edges + 1;
            else begin
                mosi_log  = {mosi_log[62:0], spi_mosi_o};
                mosi_bits = mosi_bits + 1;
                if (cyc - t_fall != HALF_DIV) half_err = half_err + 1;
                if (mosi_bits == 32 && rd_base == 32) t_cfg_end = cyc;
            end
        end
        prev_cs   = spi_cs_n_o;
        prev_sclk = spi_sclk_o;
    end

    function automatic logic [31:0] exp_frame(input logic [7:0] cmd, input logic [23:0] body);
        exp_frame = {cmd, body};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input bit wr, input logic [23:0] cfg, input int settle,
                           input logic [23:0] word, input bit poke);
        int vld_before;
        int waited;
        longint ref_t;
        longint gap;
        rd_base  = wr ? 32 : 0;
        dev_word = word;
        vld_before = vld_cnt;
        @(negedge clk);
        start_i = 1'b1; cfg_wr_i = wr; cfg_word_i = cfg;
        settle_cycles_i = DLY_W'(settle);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9", "busy after start", 64'(busy_o), 64'd1);
        if (poke) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1; cfg_wr_i = ~wr; cfg_word_i = ~cfg;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!result_vld_o && waited < settle + 2000) begin
            @(negedge clk);
            waited++;
        end
        check(result_vld_o == 1'b1, "R7", "valid seen", 64'(result_vld_o), 64'd1);
        check(result_o == word, "R7", "result word", 64'(result_o), 64'(word));
        check(spi_cs_n_o == 1'b1 && busy_o == 1'b0, "R9", "cs high busy low at valid",
              {62'd0, spi_cs_n_o, busy_o}, 64'd2);
        @(negedge clk);
        check(result_vld_o == 1'b0, "R8", "valid one cycle", 64'(result_vld_o), 64'd0);
        check(vld_cnt - vld_before == 1, "R9", "one result per start",
              64'(vld_cnt - vld_before), 64'd1);
        check(mosi_bits == rd_base + 32, wr ? "R3" : "R4", "frame bit count",
              64'(mosi_bits), 64'(rd_base + 32));
        check(mosi_log[31:0] == exp_frame(8'h58, 24'h0), "R5", "read command and idle mosi",
              64'(mosi_log[31:0]), 64'(exp_frame(8'h58, 24'h0)));
        if (wr)
            check(mosi_log[63:32] == exp_frame(8'h10, cfg), "R3", "config frame",
                  64'(mosi_log[63:32]), 64'(exp_frame(8'h10, cfg)));
        check(idle_edges == 0, "R1", "no clock with cs high", 64'(idle_edges), 64'd0);
        check(half_err == 0, "R2", "half period length", 64'(half_err), 64'd0);
        ref_t = wr ? t_cfg_end : t_cs;
        gap   = t_rd_fall - ref_t;
        check(gap >= settle && gap <= settle + 2*HALF_DIV + 8, "R6", "settle gap",
              64'(gap), 64'(settle));
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n_o && spi_sclk_o && !spi_mosi_o && !busy_o && !result_vld_o, "R10",
              "reset state",
              {59'd0, spi_cs_n_o, spi_sclk_o, spi_mosi_o, busy_o, result_vld_o}, 64'h18);
        // directed corners
        run_txn(1'b0, 24'h000000, 0,   24'h000000, 1'b0);
        run_txn(1'b1, 24'hFFFFFF, 0,   24'hFFFFFF, 1'b0);
        run_txn(1'b1, 24'h100010, 150, 24'h800000, 1'b0);
        run_txn(1'b0, 24'h5A5A5A, 40,  24'h000001, 1'b1);
        run_txn(1'b1, 24'h800107, 3,   24'hA5C3E1, 1'b1);
        // seeded random
        for (int i = 0; i < 20; i++) begin
            run_txn(1'($urandom), 24'($urandom), int'($urandom % 41),
                    24'($urandom), ($urandom % 4) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a miscompare and still summarised.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", WATCHDOG, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule